// File: doc/BRIEF.md
# Ping-Pong Receive Endpoint Buffer

This block is the receive half of a full-speed bulk OUT endpoint. A protocol engine sits upstream. It marks the start of each data packet with a token strobe, streams the payload one byte per valid cycle, and then marks the end with an end strobe. The block decides whether it can accept the packet and stores the accepted bytes. One cycle after the end strobe it answers with a single-cycle ACK or NAK pulse. Serial coding, CRC and bit stuffing are handled upstream.

The block has three modes. In single mode only one packet bank is used, and any packet that arrives while that bank is occupied is refused. In ping-pong mode two banks alternate. The CPU can work on one bank while the next packet lands in the other, so a refusal happens only when both banks are occupied.

In multi-packet mode, successive packets are laid end to end in one transfer area. The transfer finishes when a short packet arrives or when the programmed length is reached, and only then is the CPU interrupted. On the CPU side the block offers the bank flags, the byte counts, the running transfer total, a sticky interrupt with a write-one-to-clear strobe, and a read port into the packet memory.

Top module: `pp_rx_endpoint`

## Requirements
- R1: After reset, both bank-full flags are 0, both bank byte counts are 0, the bank pointer is 0, the transfer total is 0, the interrupt is low, and neither handshake pulse is active.
- R2: The mode is encoded as 00 single, 01 ping-pong and 10 multi-packet. In ping-pong mode, an accepted packet goes into the bank named by the pointer if that bank is free, and into the other bank otherwise. That bank's full flag is set and its byte count is recorded. The ACK pulse is high for exactly one cycle, one cycle after the end strobe, and ACK and NAK are never high together.
- R3: The eligibility decision is made at the token strobe. A packet is NAKed only when no eligible bank is free: both banks in ping-pong mode, bank 0 in single mode, or a finished and uncleared transfer in multi-packet mode. A NAKed packet changes no full flag, byte count, pointer, transfer total or interrupt.
- R4: After each accepted packet, the pointer moves to the bank opposite the one just filled in ping-pong mode, and toggles in multi-packet mode. In single mode it stays 0.
- R5: A 1 on bit b of the release input clears the full flag of bank b.
- R6: A bank holds at most 64 bytes. Bytes beyond the 64th are dropped, and the recorded byte count saturates at 64.
- R7: In single mode only bank 0 is ever filled. Bank 1's flag and count stay untouched.
- R8: In multi-packet mode, each accepted packet is stored starting at the memory offset equal to the transfer total so far. The total grows by the number of bytes stored.
- R9: A multi-packet transfer ends when a packet shorter than 64 bytes is accepted or when the total reaches the programmed length, whichever comes first. Bytes beyond the programmed length are dropped. The interrupt rises only at that end, never for the earlier packets.
- R10: After a multi-packet transfer ends, further packets are NAKed until the interrupt is cleared. Clearing it returns the total to 0 and accepts packets again.
- R11: The interrupt stays high until the clear strobe is pulsed. In single and ping-pong modes it is set by every accepted packet.
- R12: The read data port returns the byte at the read address one cycle later. Bank 0 occupies offsets 0 to 63, bank 1 occupies offsets 64 to 127, and a multi-packet transfer starts at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 00 single, 01 ping-pong, 10 multi-packet |
| cfg_xfer_len | input | 9 | Programmed multi-packet transfer length in bytes |
| tok_out | input | 1 | Start of an OUT data packet |
| rx_valid | input | 1 | Payload byte valid |
| rx_data | input | 8 | Payload byte |
| rx_end | input | 1 | End of packet, good data |
| hs_ack | output | 1 | ACK handshake pulse |
| hs_nak | output | 1 | NAK handshake pulse |
| bank_release | input | 2 | Per-bank release strobe from CPU |
| irq_w1c | input | 1 | Interrupt clear strobe |
| bank_full | output | 2 | Per-bank full flags |
| bank0_cnt | output | 7 | Bytes held in bank 0 |
| bank1_cnt | output | 7 | Bytes held in bank 1 |
| bank_ptr | output | 1 | Even/odd bank pointer |
| xfer_count | output | 9 | Multi-packet running total |
| irq | output | 1 | Transfer-complete interrupt |
| rd_addr | input | 8 | CPU read address into packet memory |
| rd_data | output | 8 | Byte at rd_addr, one cycle later |

## Verification
The handshake pulse, the bank flags and counts, the pointer, the transfer total and the interrupt are all registered at the clock edge that samples the end strobe. The bench therefore drives the end strobe at a falling edge and samples every one of these results at the next falling edge. Release and clear strobes take effect at the following rising edge, and their results are sampled at the falling edge after it. Read data is due one edge after the address is applied, and it is likewise read one falling edge after the address is set.

// File: rtl/pp_ep_pkg.sv
// Shared types for the ping-pong receive endpoint.
// Assumes: the mode field is static while packets are in flight.
package pp_ep_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_PINGPONG = 2'b01,
        MODE_MULTI    = 2'b10
    } ep_mode_e;
endpackage

// File: rtl/pp_ep_rx_front.sv
// Packet front end: latches the accept decision at the token strobe,
// counts payload bytes, generates memory writes inside the granted window
// and issues the registered ACK/NAK pulse after the end strobe.
// Assumes: rx_end never coincides with rx_valid; XFER_BYTES >= 2*MAX_PKT.
module pp_ep_rx_front #(
    parameter int MAX_PKT    = 64,
    parameter int XFER_BYTES = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tok_out,
    input  logic                              rx_valid,
    input  logic [7:0]                        rx_data,
    input  logic                              rx_end,
    input  logic                              grant,
    input  logic                              grant_bank,
    input  logic [$clog2(XFER_BYTES)-1:0]     grant_base,
    input  logic [$clog2(XFER_BYTES+1)-1:0]   grant_limit,
    output logic                              wr_en,
    output logic [$clog2(XFER_BYTES)-1:0]     wr_addr,
    output logic [7:0]                        wr_data,
    output logic                              commit_ok,
    output logic                              commit_short,
    output logic                              commit_bank,
    output logic [$clog2(XFER_BYTES+1)-1:0]   commit_stored,
    output logic                              hs_ack,
    output logic                              hs_nak
);
    localparam int AW  = $clog2(XFER_BYTES);
    localparam int XLW = $clog2(XFER_BYTES+1);
    localparam int CW  = $clog2(MAX_PKT+1);

    logic           busy;
    logic           acc;
    logic           bank_q;
    logic [AW-1:0]  base_q;
    logic [XLW-1:0] limit_q;
    logic [CW-1:0]  len_q;
    logic [XLW-1:0] len_x;
    logic           commit;

    // Widen the byte count for comparison against the window limit.
    always_comb len_x = XLW'(len_q);

    // Write strobe and address for a byte inside the granted window.
    always_comb begin
        wr_en   = busy && acc && rx_valid && (len_q < CW'(MAX_PKT)) && (len_x < limit_q);
        wr_addr = base_q + AW'(len_q);
        wr_data = rx_data;
    end

    // End-of-packet summary handed to the bank and transfer trackers.
    always_comb begin
        commit        = busy && rx_end;
        commit_ok     = commit && acc;
        commit_short  = len_q < CW'(MAX_PKT);
        commit_bank   = bank_q;
        commit_stored = (len_x > limit_q) ? limit_q : len_x;
    end

    // Packet context: decision latch at token, byte count during payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            acc     <= 1'b0;
            bank_q  <= 1'b0;
            base_q  <= '0;
            limit_q <= '0;
            len_q   <= '0;
        end else if (tok_out) begin
            busy    <= 1'b1;
            acc     <= grant;
            bank_q  <= grant_bank;
            base_q  <= grant_base;
            limit_q <= grant_limit;
            len_q   <= '0;
        end else if (commit) begin
            busy <= 1'b0;
        end else if (busy && rx_valid && (len_q != CW'(MAX_PKT))) begin
            len_q <= len_q + 1'b1;
        end
    end

    // Registered handshake pulse, one cycle after the end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_ack <= 1'b0;
            hs_nak <= 1'b0;
        end else begin
            hs_ack <= commit && acc;
            hs_nak <= commit && !acc;
        end
    end
endmodule

// File: rtl/pp_ep_bank_ctrl.sv
// Bank bookkeeping: full flags, byte counts and the even/odd pointer.
// Picks the target bank for the next packet (pointer bank if free,
// otherwise the other one) and reports whether any eligible bank is free.
// Assumes: a release and a fill of the same bank never share a cycle.
module pp_ep_bank_ctrl #(
    parameter int MAX_PKT    = 64,
    parameter int XFER_BYTES = 256
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            is_single,
    input  logic                            is_multi,
    input  logic [1:0]                      bank_release,
    input  logic                            commit_ok,
    input  logic                            commit_bank,
    input  logic [$clog2(XFER_BYTES+1)-1:0] commit_stored,
    output logic [1:0]                      bank_full,
    output logic [$clog2(MAX_PKT+1)-1:0]    bank0_cnt,
    output logic [$clog2(MAX_PKT+1)-1:0]    bank1_cnt,
    output logic                            bank_ptr,
    output logic                            bank_grant,
    output logic                            bank_tgt
);
    localparam int CW = $clog2(MAX_PKT+1);
    localparam int NB = 2;

    logic [CW-1:0] cnt_q [NB];

    // Target selection: single mode pins bank 0, else prefer the pointer bank.
    always_comb begin
        if (is_single)
            bank_tgt = 1'b0;
        else
            bank_tgt = bank_full[bank_ptr] ? ~bank_ptr : bank_ptr;
        bank_grant = !bank_full[bank_tgt];
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        // Per-bank flag and count: fill on accepted commit, clear on release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_full[b] <= 1'b0;
                cnt_q[b]     <= '0;
            end else if (commit_ok && !is_multi && (commit_bank == 1'(b))) begin
                bank_full[b] <= 1'b1;
                cnt_q[b]     <= CW'(commit_stored);
            end else if (bank_release[b]) begin
                bank_full[b] <= 1'b0;
            end
        end
    end

    always_comb begin
        bank0_cnt = cnt_q[0];
        bank1_cnt = cnt_q[1];
    end

    // Pointer: opposite of the filled bank (ping-pong), toggle (multi).
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_ptr <= 1'b0;
        else if (commit_ok) begin
            if (is_multi)
                bank_ptr <= ~bank_ptr;
            else if (!is_single)
                bank_ptr <= ~commit_bank;
        end
    end
endmodule

// File: rtl/pp_ep_xfer_track.sv
// Transfer tracker: running multi-packet total, completion detection on a
// short packet or on reaching the programmed length, and the sticky
// interrupt. Clearing the interrupt also rearms the transfer.
// Assumes: cfg_len is programmed before a transfer starts.
module pp_ep_xfer_track #(
    parameter int MAX_PKT    = 64,
    parameter int XFER_BYTES = 256
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            is_multi,
    input  logic [$clog2(XFER_BYTES+1)-1:0] cfg_len,
    input  logic                            commit_ok,
    input  logic                            commit_short,
    input  logic [$clog2(XFER_BYTES+1)-1:0] commit_stored,
    input  logic                            irq_w1c,
    output logic [$clog2(XFER_BYTES+1)-1:0] total,
    output logic [$clog2(XFER_BYTES+1)-1:0] remaining,
    output logic                            xfer_grant,
    output logic                            irq
);
    localparam int XLW = $clog2(XFER_BYTES+1);

    logic           done;
    logic [XLW-1:0] cap;
    logic [XLW-1:0] sum;

    // Effective length, space left and the grant for the next packet.
    always_comb begin
        cap        = (cfg_len > XLW'(XFER_BYTES)) ? XLW'(XFER_BYTES) : cfg_len;
        remaining  = (total >= cap) ? '0 : (cap - total);
        xfer_grant = !done && (remaining != '0);
        sum        = total + commit_stored;
    end

    // Total, completion and interrupt; a new set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
            done  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (irq_w1c) begin
                total <= '0;
                done  <= 1'b0;
                irq   <= 1'b0;
            end
            if (commit_ok) begin
                if (is_multi) begin
                    total <= sum;
                    if (commit_short || (sum >= cap)) begin
                        done <= 1'b1;
                        irq  <= 1'b1;
                    end
                end else begin
                    irq <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pp_ep_mem.sv
// Packet byte memory: one write port from the receive side and one
// registered read port for the CPU.
// Assumes: contents are undefined until written.
module pp_ep_mem #(
    parameter int XFER_BYTES = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(XFER_BYTES)-1:0] wr_addr,
    input  logic [7:0]                    wr_data,
    input  logic [$clog2(XFER_BYTES)-1:0] rd_addr,
    output logic [7:0]                    rd_data
);
    logic [7:0] store [XFER_BYTES];

    // Byte write from the packet front end.
    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= wr_data;
    end

    // Registered CPU read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/pp_rx_endpoint.sv
// Top of the ping-pong receive endpoint. Routes the accept decision and
// write window from the bank controller (single/ping-pong) or the transfer
// tracker (multi-packet) into the packet front end.
// Assumes: cfg_mode and cfg_xfer_len change only while idle or in reset.
module pp_rx_endpoint #(
    parameter int MAX_PKT    = 64,
    parameter int XFER_BYTES = 256
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      cfg_mode,
    input  logic [$clog2(XFER_BYTES+1)-1:0] cfg_xfer_len,
    input  logic                            tok_out,
    input  logic                            rx_valid,
    input  logic [7:0]                      rx_data,
    input  logic                            rx_end,
    output logic                            hs_ack,
    output logic                            hs_nak,
    input  logic [1:0]                      bank_release,
    input  logic                            irq_w1c,
    output logic [1:0]                      bank_full,
    output logic [$clog2(MAX_PKT+1)-1:0]    bank0_cnt,
    output logic [$clog2(MAX_PKT+1)-1:0]    bank1_cnt,
    output logic                            bank_ptr,
    output logic [$clog2(XFER_BYTES+1)-1:0] xfer_count,
    output logic                            irq,
    input  logic [$clog2(XFER_BYTES)-1:0]   rd_addr,
    output logic [7:0]                      rd_data
);
    import pp_ep_pkg::*;

    localparam int AW  = $clog2(XFER_BYTES);
    localparam int XLW = $clog2(XFER_BYTES+1);

    ep_mode_e       mode;
    logic           is_single, is_multi;
    logic           bank_grant, bank_tgt, xfer_grant;
    logic [XLW-1:0] remaining;
    logic           grant;
    logic [AW-1:0]  grant_base;
    logic [XLW-1:0] grant_limit;
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic [7:0]     wr_data;
    logic           commit_ok, commit_short, commit_bank;
    logic [XLW-1:0] commit_stored;

    // Mode decode; the unused code behaves as single mode.
    always_comb begin
        mode      = ep_mode_e'(cfg_mode);
        is_multi  = (mode == MODE_MULTI);
        is_single = !is_multi && (mode != MODE_PINGPONG);
    end

    // Accept decision and write window for the next token.
    always_comb begin
        if (is_multi) begin
            grant       = xfer_grant;
            grant_base  = AW'(xfer_count);
            grant_limit = remaining;
        end else begin
            grant       = bank_grant;
            grant_base  = bank_tgt ? AW'(MAX_PKT) : '0;
            grant_limit = XLW'(MAX_PKT);
        end
    end

    pp_ep_rx_front #(.MAX_PKT(MAX_PKT), .XFER_BYTES(XFER_BYTES)) u_front (
        .clk(clk), .rst_n(rst_n),
        .tok_out(tok_out), .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .grant(grant), .grant_bank(bank_tgt), .grant_base(grant_base),
        .grant_limit(grant_limit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_ok(commit_ok), .commit_short(commit_short), .commit_bank(commit_bank),
        .commit_stored(commit_stored), .hs_ack(hs_ack), .hs_nak(hs_nak)
    );

    pp_ep_bank_ctrl #(.MAX_PKT(MAX_PKT), .XFER_BYTES(XFER_BYTES)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .is_single(is_single), .is_multi(is_multi), .bank_release(bank_release),
        .commit_ok(commit_ok), .commit_bank(commit_bank), .commit_stored(commit_stored),
        .bank_full(bank_full), .bank0_cnt(bank0_cnt), .bank1_cnt(bank1_cnt),
        .bank_ptr(bank_ptr), .bank_grant(bank_grant), .bank_tgt(bank_tgt)
    );

    pp_ep_xfer_track #(.MAX_PKT(MAX_PKT), .XFER_BYTES(XFER_BYTES)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .is_multi(is_multi), .cfg_len(cfg_xfer_len),
        .commit_ok(commit_ok), .commit_short(commit_short), .commit_stored(commit_stored),
        .irq_w1c(irq_w1c), .total(xfer_count), .remaining(remaining),
        .xfer_grant(xfer_grant), .irq(irq)
    );

    pp_ep_mem #(.XFER_BYTES(XFER_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/pp_rx_endpoint_chk.sv
// Property checker for the ping-pong receive endpoint, bound to the top.
// Assumes: mode and programmed length are stable outside reset.
module pp_rx_endpoint_chk #(
    parameter int MAX_PKT    = 64,
    parameter int XFER_BYTES = 256
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [1:0]                      cfg_mode,
    input logic [$clog2(XFER_BYTES+1)-1:0] cfg_xfer_len,
    input logic                            hs_ack,
    input logic                            hs_nak,
    input logic                            irq_w1c,
    input logic [1:0]                      bank_full,
    input logic [$clog2(MAX_PKT+1)-1:0]    bank0_cnt,
    input logic [$clog2(MAX_PKT+1)-1:0]    bank1_cnt,
    input logic [$clog2(XFER_BYTES+1)-1:0] xfer_count,
    input logic                            irq
);
    localparam int CW = $clog2(MAX_PKT+1);

    assert_one_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_ack, hs_nak}));

    assert_fill_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(bank_full & ~$past(bank_full))) |-> hs_ack);

    assert_nak_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_nak |-> ($stable(bank0_cnt) && $stable(bank1_cnt) && $stable(xfer_count)));

    assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank0_cnt <= CW'(MAX_PKT)) && (bank1_cnt <= CW'(MAX_PKT)));

    assert_single_no_bank1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_full[1]) |-> (cfg_mode != 2'b00));

    assert_total_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10) |-> (xfer_count <= cfg_xfer_len));

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_w1c));
endmodule

bind pp_rx_endpoint pp_rx_endpoint_chk #(.MAX_PKT(MAX_PKT), .XFER_BYTES(XFER_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_xfer_len(cfg_xfer_len),
    .hs_ack(hs_ack), .hs_nak(hs_nak), .irq_w1c(irq_w1c), .bank_full(bank_full),
    .bank0_cnt(bank0_cnt), .bank1_cnt(bank1_cnt), .xfer_count(xfer_count), .irq(irq)
);

// File: tb/pp_rx_endpoint_test.sv
`timescale 1ns/1ps
module pp_rx_endpoint_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [8:0] cfg_xfer_len = 9'd0;
    logic       tok_out = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       hs_ack, hs_nak;
    logic [1:0] bank_release = 2'b00;
    logic       irq_w1c = 1'b0;
    logic [1:0] bank_full;
    logic [6:0] bank0_cnt, bank1_cnt;
    logic       bank_ptr;
    logic [8:0] xfer_count;
    logic       irq;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic got_ack, got_nak;

    always #4 clk = ~clk;

    pp_rx_endpoint uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_xfer_len(cfg_xfer_len),
        .tok_out(tok_out), .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .bank_release(bank_release), .irq_w1c(irq_w1c),
        .bank_full(bank_full), .bank0_cnt(bank0_cnt), .bank1_cnt(bank1_cnt),
        .bank_ptr(bank_ptr), .xfer_count(xfer_count), .irq(irq),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Ping-pong sequence: {release[1:0], len[7:0], ack, full[1:0], ptr, bank}
    localparam logic [14:0] PP_VEC [8] = '{
        {2'b00, 8'd10, 1'b1, 2'b01, 1'b1, 1'b0},
        {2'b00, 8'd64, 1'b1, 2'b11, 1'b0, 1'b1},
        {2'b00, 8'd5,  1'b0, 2'b11, 1'b0, 1'b0},
        {2'b10, 8'd7,  1'b1, 2'b11, 1'b0, 1'b1},
        {2'b01, 8'd3,  1'b1, 2'b11, 1'b1, 1'b0},
        {2'b11, 8'd20, 1'b1, 2'b10, 1'b0, 1'b1},
        {2'b00, 8'd1,  1'b1, 2'b11, 1'b1, 1'b0},
        {2'b11, 8'd70, 1'b1, 2'b10, 1'b0, 1'b1}
    };

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode, input logic [8:0] len);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = mode;
        cfg_xfer_len = len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_pkt(input int len, input logic [7:0] seed);
        @(negedge clk);
        tok_out = 1'b1;
        @(negedge clk);
        tok_out = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data = seed + 8'(i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        got_ack = hs_ack;
        got_nak = hs_nak;
    endtask

    task automatic release_banks(input logic [1:0] m);
        @(negedge clk);
        bank_release = m;
        @(negedge clk);
        bank_release = 2'b00;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_w1c = 1'b1;
        @(negedge clk);
        irq_w1c = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rb;

        // R1 reset state, single mode
        do_reset(2'b00, 9'd0);
        check("R1 full", int'(bank_full), 0);
        check("R1 cnt0", int'(bank0_cnt), 0);
        check("R1 cnt1", int'(bank1_cnt), 0);
        check("R1 ptr", int'(bank_ptr), 0);
        check("R1 total", int'(xfer_count), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 handshake", int'({hs_ack, hs_nak}), 0);

        // R7 single mode fills bank 0 only; R4 pointer stays 0
        send_pkt(8, 8'h01);
        check("R7 ack", int'(got_ack), 1);
        check("R7 full", int'(bank_full), 1);
        check("R7 cnt0", int'(bank0_cnt), 8);
        check("R4 single ptr", int'(bank_ptr), 0);
        clear_irq();
        // R3 NAK while bank 0 held, nothing changes
        send_pkt(5, 8'h40);
        check("R3 nak", int'(got_nak), 1);
        check("R3 no ack", int'(got_ack), 0);
        check("R3 cnt0 kept", int'(bank0_cnt), 8);
        check("R3 irq kept", int'(irq), 0);
        // R5 release
        release_banks(2'b01);
        check("R5 released", int'(bank_full), 0);
        send_pkt(12, 8'h50);
        check("R7 bank0 again", int'(bank0_cnt), 12);
        check("R7 bank1 untouched", int'(bank1_cnt), 0);
        check("R7 full", int'(bank_full), 1);
        read_byte(8'd0, rb);
        check("R12 bank0 byte0", int'(rb), 8'h50);

        // Ping-pong table (R2 R3 R4 R5 R6)
        do_reset(2'b01, 9'd0);
        for (int k = 0; k < 8; k++) begin
            logic [14:0] v;
            int explen;
            v = PP_VEC[k];
            if (v[14:13] != 2'b00) release_banks(v[14:13]);
            send_pkt(int'(v[12:5]), 8'((k + 1) * 16));
            check("R2 ack", int'(got_ack), int'(v[4]));
            check("R3 nak", int'(got_nak), int'(!v[4]));
            check("R2 full", int'(bank_full), int'(v[3:2]));
            check("R4 ptr", int'(bank_ptr), int'(v[1]));
            explen = (v[12:5] > 8'd64) ? 64 : int'(v[12:5]);
            if (v[4]) begin
                if (v[0]) check("R6 cnt1", int'(bank1_cnt), explen);
                else      check("R2 cnt0", int'(bank0_cnt), explen);
            end
        end
        read_byte(8'd64, rb);
        check("R12 bank1 byte0", int'(rb), 8'h80);
        read_byte(8'd127, rb);
        check("R6 last kept byte", int'(rb), 8'hBF);
        // R11 interrupt per packet, sticky until cleared
        check("R11 irq set", int'(irq), 1);
        send_pkt(4, 8'h90);
        check("R2 fill bank0", int'(bank_full), 3);
        clear_irq();
        check("R11 irq cleared", int'(irq), 0);
        send_pkt(4, 8'hA0);
        check("R3 both full nak", int'(got_nak), 1);
        check("R3 irq stays low", int'(irq), 0);

        // Multi-packet mode (R8 R9 R10)
        do_reset(2'b10, 9'd150);
        send_pkt(64, 8'h00);
        check("R8 total", int'(xfer_count), 64);
        check("R9 no early irq", int'(irq), 0);
        check("R4 multi ptr", int'(bank_ptr), 1);
        send_pkt(64, 8'h40);
        check("R8 total", int'(xfer_count), 128);
        check("R9 no early irq", int'(irq), 0);
        send_pkt(64, 8'h80);
        check("R9 capped total", int'(xfer_count), 150);
        check("R9 irq at length", int'(irq), 1);
        send_pkt(10, 8'hC0);
        check("R10 nak after done", int'(got_nak), 1);
        check("R10 total kept", int'(xfer_count), 150);
        check("R3 ptr kept", int'(bank_ptr), 1);
        read_byte(8'd64, rb);
        check("R8 second packet offset", int'(rb), 8'h40);
        read_byte(8'd149, rb);
        check("R9 last stored byte", int'(rb), 8'h80 + 21);
        clear_irq();
        check("R10 irq clear", int'(irq), 0);
        check("R10 total reset", int'(xfer_count), 0);
        send_pkt(64, 8'h10);
        check("R10 accepts again", int'(got_ack), 1);
        check("R9 no early irq", int'(irq), 0);
        send_pkt(10, 8'h60);
        check("R9 short ends", int'(irq), 1);
        check("R8 total", int'(xfer_count), 74);
        read_byte(8'd64, rb);
        check("R12 multi offset", int'(rb), 8'h60);

        finish_run();
    end
endmodule